// File: doc/BRIEF.md
# Two-Level Shared Interrupt Aggregator

This block collects the interrupt causes of a storage-card host controller and merges them with the interrupt of a second peripheral onto one level-sensitive line. At the first level, single-cycle event pulses from the transfer and card logic set sticky bits in a cause register. A separate mask register selects which causes count. Any unmasked pending cause raises the card controller's bit in a shared top-level status word. The second peripheral's request drives the other bit of that word.

The top-level word has two mask registers of its own. One decides whether a source may be recorded in the top-level status at all. The other decides whether a recorded bit may drive the output line. Software clears any status bit, at either level, by writing a 1 to its position. The output line is registered, so it follows the gated top-level status by one clock.

Registers sit on a simple 32-bit bus with a write strobe and a combinational read port. Address map (byte offsets): cause status 0x004, cause mask 0x008, top status 0x800, top record-enable 0x804, top signal-enable 0x808.

Top module: `shared_irq_aggr`

## Requirements
- R1: While reset is high at a clock edge, every register is cleared, so all five registers read 0 afterwards and `irq_o` is low.
- R2: A pulse on `card_evt` bit 0, 1, 2, 3, 8, 9, 10 or 11 sets that bit of the cause status (0x004) from the next clock on. Cause bits 4 to 7 and 12 to 31 do not exist, always read 0, and ignore events.
- R3: Writing the cause status clears each bit where the write data holds 1. Bits written with 0 keep their value.
- R4: When an event and a clearing write hit the same cause bit in the same cycle, the bit ends up set.
- R5: The cause mask (0x008) stores the write data for bits 0-3 and 8-11 and reads 0 in every other position.
- R6: Top status bit 0 becomes set on the clock after a cycle in which (cause status AND cause mask) is nonzero and record-enable bit 0 is 1. Once set, it stays set until cleared by a write, even after the local cause goes away.
- R7: Top status bit 1 becomes set on the clock after a cycle in which `peer_irq` is high and record-enable bit 1 is 1. With record-enable bit 1 at 0, `peer_irq` has no effect.
- R8: Writing 1 to a top status bit (0x800) clears it, unless its setting condition holds in the same cycle, in which case the bit stays set.
- R9: `irq_o` equals, one clock later, the OR over both bits of (top status AND signal-enable).
- R10: Record-enable (0x804) and signal-enable (0x808) store write data bits 1:0 and read 0 above them. A read of any other address returns 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 12 | Byte address for reads and writes |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data of the register at `reg_addr` (combinational) |
| card_evt | input | 12 | Single-cycle event pulses, one per cause position |
| peer_irq | input | 1 | Request from the second sharing peripheral |
| irq_o | output | 1 | Combined level-sensitive interrupt |

## Verification
A corrupted cause or mask bit shows at the read port as soon as that register is addressed. Within two clocks it also shows as a wrong top status bit 0, and within three as a wrong level on `irq_o`. A lost sticky bit, or a clear that wins against a simultaneous event, appears as an interrupt line that drops while the reference still holds it high. The line is compared with a reference on every clock, so a single-cycle deviation is caught in the cycle it happens. A bad record-enable or signal-enable bit shows as a top-level bit or an output that appears when the reference says it must not, or fails to appear when it must.

// File: rtl/shared_irq_pkg.sv
package shared_irq_pkg;

    localparam int DATA_W   = 32;
    localparam int ADDR_W   = 12;
    localparam int LOCAL_W  = 12;
    localparam int GLOBAL_W = 2;

    // implemented cause positions: 0..3 and 8..11
    localparam logic [LOCAL_W-1:0] LOCAL_IMPL = 12'hF0F;

    localparam logic [ADDR_W-1:0] A_CAUSE_STS = 12'h004;
    localparam logic [ADDR_W-1:0] A_CAUSE_MSK = 12'h008;
    localparam logic [ADDR_W-1:0] A_TOP_STS   = 12'h800;
    localparam logic [ADDR_W-1:0] A_TOP_REC   = 12'h804;
    localparam logic [ADDR_W-1:0] A_TOP_SIG   = 12'h808;

    // top-level source positions
    localparam int SRC_CARD = 0;
    localparam int SRC_PEER = 1;

    typedef struct packed {
        logic cause_sts;
        logic cause_msk;
        logic top_sts;
        logic top_rec;
        logic top_sig;
    } wr_hit_t;

    // sticky bit update: a set in the same cycle beats a clear
    function automatic logic sticky_next(logic cur, logic clr, logic set);
        return (cur & ~clr) | set;
    endfunction

endpackage

// File: rtl/irq_local_bank.sv
module irq_local_bank
    import shared_irq_pkg::*;
#(
    parameter int                 W    = LOCAL_W,
    parameter logic [LOCAL_W-1:0] IMPL = LOCAL_IMPL
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] evt,
    input  logic [W-1:0] clr,
    input  logic         msk_we,
    input  logic [W-1:0] msk_wdata,
    output logic [W-1:0] sts_q,
    output logic [W-1:0] msk_q,
    output logic         cause
);

    for (genvar i = 0; i < W; i++) begin : g_bit
        if (IMPL[i]) begin : g_impl
            always_ff @(posedge clk) begin
                if (rst) begin
                    sts_q[i] <= 1'b0;
                    msk_q[i] <= 1'b0;
                end else begin
                    sts_q[i] <= sticky_next(sts_q[i], clr[i], evt[i]);
                    if (msk_we) msk_q[i] <= msk_wdata[i];
                end
            end
        end else begin : g_none
            assign sts_q[i] = 1'b0;
            assign msk_q[i] = 1'b0;
        end
    end

    assign cause = |(sts_q & msk_q);

endmodule

// File: rtl/irq_global_bank.sv
module irq_global_bank
    import shared_irq_pkg::*;
#(
    parameter int W = GLOBAL_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] src,
    input  logic [W-1:0] clr,
    input  logic         rec_we,
    input  logic [W-1:0] rec_wdata,
    input  logic         sig_we,
    input  logic [W-1:0] sig_wdata,
    output logic [W-1:0] sts_q,
    output logic [W-1:0] rec_q,
    output logic [W-1:0] sig_q,
    output logic         pend
);

    for (genvar i = 0; i < W; i++) begin : g_src
        always_ff @(posedge clk) begin
            if (rst) begin
                sts_q[i] <= 1'b0;
                rec_q[i] <= 1'b0;
                sig_q[i] <= 1'b0;
            end else begin
                sts_q[i] <= sticky_next(sts_q[i], clr[i], src[i] & rec_q[i]);
                if (rec_we) rec_q[i] <= rec_wdata[i];
                if (sig_we) sig_q[i] <= sig_wdata[i];
            end
        end
    end

    assign pend = |(sts_q & sig_q);

endmodule

// File: rtl/irq_out_stage.sv
module irq_out_stage (
    input  logic clk,
    input  logic rst,
    input  logic pend,
    output logic irq
);

    always_ff @(posedge clk) begin
        if (rst) irq <= 1'b0;
        else     irq <= pend;
    end

endmodule

// File: rtl/shared_irq_aggr.sv
module shared_irq_aggr
    import shared_irq_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               reg_wr,
    input  logic [ADDR_W-1:0]  reg_addr,
    input  logic [DATA_W-1:0]  reg_wdata,
    output logic [DATA_W-1:0]  reg_rdata,
    input  logic [LOCAL_W-1:0] card_evt,
    input  logic               peer_irq,
    output logic               irq_o
);

    wr_hit_t               hit;
    logic [LOCAL_W-1:0]    loc_sts, loc_msk, loc_clr;
    logic                  loc_cause;
    logic [GLOBAL_W-1:0]   top_sts, top_rec, top_sig, top_clr, top_src;
    logic                  top_pend;

    always_comb begin
        hit.cause_sts = reg_wr && (reg_addr == A_CAUSE_STS);
        hit.cause_msk = reg_wr && (reg_addr == A_CAUSE_MSK);
        hit.top_sts   = reg_wr && (reg_addr == A_TOP_STS);
        hit.top_rec   = reg_wr && (reg_addr == A_TOP_REC);
        hit.top_sig   = reg_wr && (reg_addr == A_TOP_SIG);
    end

    assign loc_clr = hit.cause_sts ? reg_wdata[LOCAL_W-1:0] : '0;
    assign top_clr = hit.top_sts ? reg_wdata[GLOBAL_W-1:0] : '0;

    always_comb begin
        top_src           = '0;
        top_src[SRC_CARD] = loc_cause;
        top_src[SRC_PEER] = peer_irq;
    end

    irq_local_bank #(.W(LOCAL_W), .IMPL(LOCAL_IMPL)) u_local (
        .clk       (clk),
        .rst       (rst),
        .evt       (card_evt),
        .clr       (loc_clr),
        .msk_we    (hit.cause_msk),
        .msk_wdata (reg_wdata[LOCAL_W-1:0]),
        .sts_q     (loc_sts),
        .msk_q     (loc_msk),
        .cause     (loc_cause)
    );

    irq_global_bank #(.W(GLOBAL_W)) u_global (
        .clk       (clk),
        .rst       (rst),
        .src       (top_src),
        .clr       (top_clr),
        .rec_we    (hit.top_rec),
        .rec_wdata (reg_wdata[GLOBAL_W-1:0]),
        .sig_we    (hit.top_sig),
        .sig_wdata (reg_wdata[GLOBAL_W-1:0]),
        .sts_q     (top_sts),
        .rec_q     (top_rec),
        .sig_q     (top_sig),
        .pend      (top_pend)
    );

    irq_out_stage u_out (
        .clk  (clk),
        .rst  (rst),
        .pend (top_pend),
        .irq  (irq_o)
    );

    always_comb begin
        reg_rdata = '0;
        unique case (reg_addr)
            A_CAUSE_STS: reg_rdata[LOCAL_W-1:0]  = loc_sts;
            A_CAUSE_MSK: reg_rdata[LOCAL_W-1:0]  = loc_msk;
            A_TOP_STS:   reg_rdata[GLOBAL_W-1:0] = top_sts;
            A_TOP_REC:   reg_rdata[GLOBAL_W-1:0] = top_rec;
            A_TOP_SIG:   reg_rdata[GLOBAL_W-1:0] = top_sig;
            default:     reg_rdata = '0;
        endcase
    end

endmodule

// File: rtl/shared_irq_aggr_chk.sv
module shared_irq_aggr_chk
    import shared_irq_pkg::*;
(
    input logic               clk,
    input logic               rst,
    input logic               reg_wr,
    input logic [ADDR_W-1:0]  reg_addr,
    input logic [DATA_W-1:0]  reg_wdata,
    input logic [LOCAL_W-1:0] card_evt,
    input logic               peer_irq,
    input logic               irq_o,
    input logic [LOCAL_W-1:0] loc_sts,
    input logic [LOCAL_W-1:0] loc_msk,
    input logic [GLOBAL_W-1:0] top_sts,
    input logic [GLOBAL_W-1:0] top_rec,
    input logic [GLOBAL_W-1:0] top_sig
);

    // R1
    reset_quiet_chk: assert property (@(posedge clk) rst |=> !irq_o);

    // R4
    event_sets_chk: assert property (@(posedge clk) disable iff (rst)
        (|(card_evt & LOCAL_IMPL)) |=>
        ((loc_sts & $past(card_evt & LOCAL_IMPL)) == $past(card_evt & LOCAL_IMPL)));

    // R6
    card_rec_chk: assert property (@(posedge clk) disable iff (rst)
        ((|(loc_sts & loc_msk)) && top_rec[SRC_CARD]) |=> top_sts[SRC_CARD]);

    // R7
    peer_rec_chk: assert property (@(posedge clk) disable iff (rst)
        (peer_irq && top_rec[SRC_PEER]) |=> top_sts[SRC_PEER]);

    // R8
    top_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (top_sts[SRC_CARD] && !(reg_wr && reg_addr == A_TOP_STS && reg_wdata[SRC_CARD]))
        |=> top_sts[SRC_CARD]);

    // R9
    irq_follow_chk: assert property (@(posedge clk) disable iff (rst)
        $past(!rst) |-> (irq_o == $past(|(top_sts & top_sig))));

endmodule

bind shared_irq_aggr shared_irq_aggr_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .card_evt  (card_evt),
    .peer_irq  (peer_irq),
    .irq_o     (irq_o),
    .loc_sts   (loc_sts),
    .loc_msk   (loc_msk),
    .top_sts   (top_sts),
    .top_rec   (top_rec),
    .top_sig   (top_sig)
);

// File: tb/shared_irq_aggr_bench.sv
module shared_irq_aggr_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_wr = 1'b0;
    logic [11:0] reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [11:0] card_evt = '0;
    logic        peer_irq = 1'b0;
    logic        irq_o;

    int total = 0;
    int bad   = 0;
    bit finished = 0;

    // behavioural reference
    int m_cs, m_cm, m_ts, m_tr, m_tg;
    bit m_irq;

    always #4 clk = ~clk;   // 125 MHz

    shared_irq_aggr u_shared_irq_aggr (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .card_evt(card_evt),
        .peer_irq(peer_irq), .irq_o(irq_o)
    );

    always @(posedge clk) begin
        if (rst) begin
            m_cs <= 0; m_cm <= 0; m_ts <= 0; m_tr <= 0; m_tg <= 0; m_irq <= 0;
        end else begin
            int ncs, nts;
            ncs = m_cs;
            if (reg_wr && reg_addr == 12'h004) ncs = ncs & ~int'(reg_wdata);
            ncs = (ncs | int'(card_evt)) & 'hF0F;
            m_cs <= ncs;
            if (reg_wr && reg_addr == 12'h008) m_cm <= int'(reg_wdata) & 'hF0F;
            nts = m_ts;
            if (reg_wr && reg_addr == 12'h800) nts = nts & ~int'(reg_wdata);
            if ((m_cs & m_cm) != 0 && (m_tr & 1) != 0) nts = nts | 1;
            if (peer_irq && (m_tr & 2) != 0) nts = nts | 2;
            m_ts <= nts & 3;
            if (reg_wr && reg_addr == 12'h804) m_tr <= int'(reg_wdata) & 3;
            if (reg_wr && reg_addr == 12'h808) m_tg <= int'(reg_wdata) & 3;
            m_irq <= ((m_ts & m_tg) != 0);
        end
    end

    // R9: line compared with the reference every clock
    always @(negedge clk) begin
        if (!rst && !finished) begin
            total++;
            if (irq_o !== m_irq) begin
                bad++;
                $display("FAIL R9 irq_o actual=%0b expected=%0b at %0t", irq_o, m_irq, $time);
            end
        end
    end

    function automatic int model_read(logic [11:0] a);
        case (a)
            12'h004: return m_cs;
            12'h008: return m_cm;
            12'h800: return m_ts;
            12'h804: return m_tr;
            12'h808: return m_tg;
            default: return 0;
        endcase
    endfunction

    task automatic cyc(bit wr, logic [11:0] a, logic [31:0] d, logic [11:0] ev, bit peer);
        @(negedge clk);
        reg_wr = wr; reg_addr = a; reg_wdata = d; card_evt = ev; peer_irq = peer;
        @(negedge clk);
        reg_wr = 1'b0; card_evt = '0; peer_irq = 1'b0;
    endtask

    task automatic wr(logic [11:0] a, logic [31:0] d);
        cyc(1'b1, a, d, '0, 1'b0);
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // read check against the reference and against a value fixed by the requirement
    task automatic rd(logic [11:0] a, int exp, string req);
        int mv;
        @(negedge clk);
        reg_addr = a;
        #1;
        mv = model_read(a);
        total++;
        if (reg_rdata !== 32'(exp) || mv != exp) begin
            bad++;
            $display("FAIL %s addr=%h actual=%h expected=%h model=%h", req, a, reg_rdata, exp, mv);
        end
    endtask

    task automatic chk_irq(bit exp, string req);
        @(negedge clk);
        #1;
        total++;
        if (irq_o !== exp) begin
            bad++;
            $display("FAIL %s irq_o actual=%0b expected=%0b", req, irq_o, exp);
        end
    endtask

    initial begin
        #(8 * 200000);
        total++; bad++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        idle(3);
        @(negedge clk); rst = 1'b0;
        // R1 reset state
        rd(12'h004, 0, "R1"); rd(12'h008, 0, "R1"); rd(12'h800, 0, "R1");
        rd(12'h804, 0, "R1"); rd(12'h808, 0, "R1"); chk_irq(1'b0, "R1");

        // R5 mask holds implemented bits only
        wr(12'h008, 32'hFFFF_FFFF);
        rd(12'h008, 'hF0F, "R5");
        wr(12'h008, 32'h0000_0000);
        rd(12'h008, 0, "R5");

        // R2 events set cause bits, unimplemented positions ignored
        cyc(1'b0, 12'h000, 0, 12'h401, 1'b0);
        rd(12'h004, 'h401, "R2");
        cyc(1'b0, 12'h000, 0, 12'h0F0, 1'b0);
        rd(12'h004, 'h401, "R2");
        cyc(1'b0, 12'h000, 0, 12'hB0E, 1'b0);
        rd(12'h004, 'hF0F, "R2");

        // R6 mask zero: nothing at top level even with record-enable
        wr(12'h804, 32'h1);
        idle(2);
        rd(12'h800, 0, "R6");

        // R3 write-one clears, zeros keep
        wr(12'h004, 32'h0000_0001);
        rd(12'h004, 'hF0E, "R3");
        wr(12'h004, 32'h0000_0000);
        rd(12'h004, 'hF0E, "R3");
        wr(12'h004, 32'h0000_0B0E);
        rd(12'h004, 'h400, "R3");

        // R4 event beats clear in same cycle
        cyc(1'b1, 12'h004, 32'h0000_0200, 12'h200, 1'b0);
        rd(12'h004, 'h600, "R4");

        // R6 unmasked cause records at top bit 0
        wr(12'h008, 32'h400);
        idle(1);
        rd(12'h800, 1, "R6");
        chk_irq(1'b0, "R9");
        // R9 signal-enable drives the line
        wr(12'h808, 32'h1);
        idle(1);
        chk_irq(1'b1, "R9");

        // R8 clear while cause still active: stays set
        wr(12'h800, 32'h1);
        rd(12'h800, 1, "R8");
        // remove local cause: top bit stays sticky (R6)
        wr(12'h004, 32'hFFF);
        idle(2);
        rd(12'h800, 1, "R6");
        wr(12'h800, 32'h1);
        rd(12'h800, 0, "R8");
        idle(1);
        chk_irq(1'b0, "R9");

        // R7 peer ignored without record-enable
        cyc(1'b0, 12'h000, 0, '0, 1'b1);
        rd(12'h800, 0, "R7");
        wr(12'h804, 32'hFFFF_FFFE);
        rd(12'h804, 2, "R10");
        cyc(1'b0, 12'h000, 0, '0, 1'b1);
        rd(12'h800, 2, "R7");
        chk_irq(1'b0, "R9");
        wr(12'h808, 32'h2);
        rd(12'h808, 2, "R10");
        idle(1);
        chk_irq(1'b1, "R9");
        // R8 peer clear and simultaneous request
        cyc(1'b1, 12'h800, 32'h2, '0, 1'b1);
        rd(12'h800, 2, "R8");
        wr(12'h800, 32'h2);
        rd(12'h800, 0, "R8");

        // R10 unmapped reads
        rd(12'h00C, 0, "R10");
        rd(12'h000, 0, "R10");
        rd(12'h80C, 0, "R10");

        // R1 reset mid-run
        wr(12'h008, 32'h1);
        cyc(1'b0, 12'h000, 0, 12'h001, 1'b1);
        @(negedge clk); rst = 1'b1;
        idle(2);
        @(negedge clk); rst = 1'b0;
        rd(12'h004, 0, "R1"); rd(12'h008, 0, "R1"); rd(12'h800, 0, "R1");
        rd(12'h804, 0, "R1"); rd(12'h808, 0, "R1"); chk_irq(1'b0, "R1");

        idle(2);
        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule